// File: doc/BRIEF.md
# Radio Control Port Command Interpreter

This block is the serial control port of a packet radio. A host drives it as an SPI slave in mode 0. Each frame opens when chip-select goes low. The first byte the host sends is a command opcode, and that opcode decides what the bytes after it do. The block holds a small configuration register file. It forwards payload bytes to an external transmit FIFO and takes them from an external receive FIFO through single-cycle push and pop strobes. Flush and reuse commands reach the FIFO logic as one-cycle pulses.

While the opcode is clocked in, the block clocks out its status byte. The host therefore sees the interrupt flags and the FIFO state at the start of every frame. The three event flags are sticky. Radio-side pulses set them, and the host clears them by writing ones.

The SPI pins are sampled with the system clock through synchronisers, so SCK must be well below a quarter of the clock rate. The command state machine has these states:
- `ST_IDLE`: chip-select high.
- `ST_CMD`: waiting for the opcode.
- `ST_REG_RD` and `ST_REG_WR`: register access.
- `ST_PLD_RD` and `ST_PLD_WR`: payload transfer.
- `ST_DISCARD`: flush, reuse, no-op and unknown opcodes.

The state machine has these transitions:
- Any state goes to `ST_IDLE` when chip-select rises.
- Any state goes to `ST_CMD` when chip-select falls.
- `ST_CMD` leaves on the first complete byte, to the state that the opcode selects.
- Every other state holds until chip-select rises.

Top module: `radio_spi_cmd`

## Requirements
- R1: Chip-select low opens a frame and chip-select high ends it. The byte returned during the opcode is the status byte, laid out as follows: bit 7 is 0, bits 6:4 are the sticky receive-done, transmit-done and retry-limit flags, bits 3:1 are 111 when the receive FIFO is empty and 000 otherwise, and bit 0 is the transmit-FIFO-full input.
- R2: Shifting is SPI mode 0 and most significant bit first. MOSI is sampled on the SCK rising edge, and MISO changes after the SCK falling edge.
- R3: Opcode 000aaaaa reads register aaaaa, and the value comes back in the next byte. Addresses above 0x17 read as 0x00, and writes to them are dropped.
- R4: Opcode 001aaaaa writes the next byte into register aaaaa. For a single-byte register, any further bytes in the same frame are ignored. After a read command, bytes beyond a register's width read as 0x00.
- R5: Registers 0x0A, 0x0B and 0x10 are 5 bytes wide. Their bytes are written and read in consecutive data bytes of one frame, byte 0 first, and every byte resets to 0xE7.
- R6: A pulse on a radio event input sets its status flag. Writing a 1 to status bit 6, 5 or 4 clears that flag, and writing a 0 leaves it unchanged. If an event and a clear arrive together, the event wins. The other status bits ignore writes.
- R7: After opcode 0xA0, each further byte produces one `tx_push` pulse that carries that byte.
- R8: After opcode 0x61, each data byte returns the receive FIFO head, and the head is popped only after the byte has been fully shifted out. When the FIFO is empty, the byte returns 0x00 and nothing is popped.
- R9: Opcodes 0xE1, 0xE2 and 0xE3 each give exactly one pulse per frame, on `tx_flush`, `rx_flush` and `tx_reuse` respectively.
- R10: Opcode 0xFF and every opcode that is not defined change no register and no FIFO. Their data bytes are ignored, and MISO returns 0x00 for them.
- R11: Register 0x17 is read-only. Bit 5 is transmit full, bit 4 is transmit empty, bit 1 is receive full and bit 0 is receive empty.
- R12: After reset, every single-byte register reads 0x00, and the status byte is 0x0E when the receive FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_csn | input | 1 | Chip-select, active low |
| spi_sck | input | 1 | Serial clock from the host |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| tx_push | output | 1 | One-cycle strobe that writes `tx_data` into the transmit FIFO |
| tx_data | output | 8 | Payload byte for the transmit FIFO |
| tx_full | input | 1 | Transmit FIFO is full |
| tx_empty | input | 1 | Transmit FIFO is empty |
| tx_flush | output | 1 | Pulse that empties the transmit FIFO |
| tx_reuse | output | 1 | Pulse that asks for the last transmit payload to be sent again |
| rx_pop | output | 1 | One-cycle strobe that removes the receive FIFO head |
| rx_data | input | 8 | Receive FIFO head byte |
| rx_empty | input | 1 | Receive FIFO is empty |
| rx_full | input | 1 | Receive FIFO is full |
| rx_flush | output | 1 | Pulse that empties the receive FIFO |
| evt_rx_done | input | 1 | Pulse from the radio: a packet was received |
| evt_tx_done | input | 1 | Pulse from the radio: a packet was sent |
| evt_retry_limit | input | 1 | Pulse from the radio: the retransmit limit was reached |

## Verification
The opcode decoder is exercised with every command class, plus one opcode outside the defined set. For each, the bench checks both the returned bytes and the side-effect strobes, which separates a wrong decode from a wrong datapath. Register access uses single-byte registers, 5-byte registers, addresses above the map, and over-long frames, which separates indexing errors from address-decode errors. The status byte is checked after set, partial clear and zero-write patterns. Payload reads run past the FIFO's end, which shows whether pops track bytes that were actually shifted out rather than bytes that were only loaded.

// File: rtl/radio_spi_pkg.sv
package radio_spi_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_REG_RD,
        ST_REG_WR,
        ST_PLD_RD,
        ST_PLD_WR,
        ST_DISCARD
    } cmd_state_e;

    localparam logic [7:0] OP_RD_PLD   = 8'h61;
    localparam logic [7:0] OP_WR_PLD   = 8'hA0;
    localparam logic [7:0] OP_FLUSH_TX = 8'hE1;
    localparam logic [7:0] OP_FLUSH_RX = 8'hE2;
    localparam logic [7:0] OP_REUSE_TX = 8'hE3;

    localparam logic [4:0] A_STATUS = 5'h07;
    localparam logic [4:0] A_FIFO   = 5'h17;
    localparam logic [4:0] A_PIPE0  = 5'h0A;
    localparam logic [4:0] A_PIPE1  = 5'h0B;
    localparam logic [4:0] A_TXADR  = 5'h10;

    localparam int NUM_WIDE = 3;

    function automatic logic [4:0] wide_addr(input int g);
        case (g)
            0:       return A_PIPE0;
            1:       return A_PIPE1;
            default: return A_TXADR;
        endcase
    endfunction

    function automatic cmd_state_e decode_op(input logic [7:0] op);
        if (op[7:5] == 3'b000)       return ST_REG_RD;
        else if (op[7:5] == 3'b001)  return ST_REG_WR;
        else if (op == OP_RD_PLD)    return ST_PLD_RD;
        else if (op == OP_WR_PLD)    return ST_PLD_WR;
        else                         return ST_DISCARD;
    endfunction

endpackage

// File: rtl/spi_shifter.sv
module spi_shifter #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       spi_csn,
    input  logic       spi_sck,
    input  logic       spi_mosi,
    input  logic [7:0] first_byte,
    input  logic [7:0] next_byte,
    output logic       spi_miso,
    output logic       frame_start,
    output logic       frame_end,
    output logic       next_taken,
    output logic       byte_done,
    output logic [7:0] rx_byte
);
    logic [SYNC_STAGES-1:0] csn_p, sck_p, mosi_p;
    logic csn_s, sck_s, mosi_s, csn_d, sck_d;
    logic sck_rise, sck_fall;
    logic [2:0] bit_cnt;
    logic [7:0] in_sh, out_sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            csn_p  <= '1;
            sck_p  <= '0;
            mosi_p <= '0;
            csn_d  <= 1'b1;
            sck_d  <= 1'b0;
        end else begin
            csn_p  <= {csn_p[SYNC_STAGES-2:0], spi_csn};
            sck_p  <= {sck_p[SYNC_STAGES-2:0], spi_sck};
            mosi_p <= {mosi_p[SYNC_STAGES-2:0], spi_mosi};
            csn_d  <= csn_s;
            sck_d  <= sck_s;
        end
    end

    assign csn_s       = csn_p[SYNC_STAGES-1];
    assign sck_s       = sck_p[SYNC_STAGES-1];
    assign mosi_s      = mosi_p[SYNC_STAGES-1];
    assign frame_start = csn_d & ~csn_s;
    assign frame_end   = ~csn_d & csn_s;
    assign sck_rise    = ~sck_d & sck_s & ~csn_s;
    assign sck_fall    = sck_d & ~sck_s & ~csn_s;
    assign next_taken  = sck_fall && (bit_cnt == 3'd0) && !frame_start;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            in_sh     <= '0;
            out_sh    <= '0;
            byte_done <= 1'b0;
            rx_byte   <= '0;
        end else begin
            byte_done <= 1'b0;
            if (frame_start) begin
                bit_cnt <= '0;
                out_sh  <= first_byte;
            end else if (csn_s) begin
                bit_cnt <= '0;
                out_sh  <= '0;
            end else begin
                if (sck_rise) begin
                    in_sh   <= {in_sh[6:0], mosi_s};
                    bit_cnt <= bit_cnt + 3'd1;
                    if (bit_cnt == 3'd7) begin
                        byte_done <= 1'b1;
                        rx_byte   <= {in_sh[6:0], mosi_s};
                    end
                end
                if (sck_fall) begin
                    if (bit_cnt == 3'd0) out_sh <= next_byte;
                    else                 out_sh <= {out_sh[6:0], 1'b0};
                end
            end
        end
    end

    assign spi_miso = out_sh[7];

    // R1: the status MSB is on MISO right after the frame opens
    assert_status_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> spi_miso == $past(first_byte[7]));

    // R2: a completed byte is reported only while the frame is open
    assert_byte_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |-> !$past(csn_s));
endmodule

// File: rtl/cmd_fsm.sv
module cmd_fsm
    import radio_spi_pkg::*;
#(
    parameter int ADDR_BYTES = 5,
    localparam int IW = $clog2(ADDR_BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    input  logic          frame_end,
    input  logic          byte_done,
    input  logic [7:0]    rx_byte,
    input  logic          next_taken,
    input  logic          rx_empty,
    output cmd_state_e    state,
    output logic [4:0]    addr,
    output logic [IW-1:0] idx,
    output logic          wr_en,
    output logic [IW-1:0] wr_idx,
    output logic [7:0]    wr_data,
    output logic          tx_push,
    output logic [7:0]    tx_data,
    output logic          rx_pop,
    output logic          tx_flush,
    output logic          rx_flush,
    output logic          tx_reuse
);
    localparam logic [IW-1:0] IDX_MAX = IW'(ADDR_BYTES);

    cmd_state_e nxt;
    logic head_vld;

    always_comb begin
        nxt = state;
        if (frame_end) begin
            nxt = ST_IDLE;
        end else if (frame_start) begin
            nxt = ST_CMD;
        end else begin
            unique case (state)
                ST_IDLE:    nxt = ST_IDLE;
                ST_CMD:     if (byte_done) nxt = decode_op(rx_byte);
                ST_REG_RD,
                ST_REG_WR,
                ST_PLD_RD,
                ST_PLD_WR,
                ST_DISCARD: nxt = state;
                default:    nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr     <= '0;
            idx      <= '0;
            wr_en    <= 1'b0;
            wr_idx   <= '0;
            wr_data  <= '0;
            tx_push  <= 1'b0;
            tx_data  <= '0;
            rx_pop   <= 1'b0;
            tx_flush <= 1'b0;
            rx_flush <= 1'b0;
            tx_reuse <= 1'b0;
            head_vld <= 1'b0;
        end else begin
            wr_en    <= 1'b0;
            tx_push  <= 1'b0;
            rx_pop   <= 1'b0;
            tx_flush <= 1'b0;
            rx_flush <= 1'b0;
            tx_reuse <= 1'b0;
            if (frame_start) begin
                idx      <= '0;
                head_vld <= 1'b0;
            end else begin
                unique case (state)
                    ST_CMD: if (byte_done) begin
                        addr     <= rx_byte[4:0];
                        idx      <= '0;
                        tx_flush <= (rx_byte == OP_FLUSH_TX);
                        rx_flush <= (rx_byte == OP_FLUSH_RX);
                        tx_reuse <= (rx_byte == OP_REUSE_TX);
                    end
                    ST_REG_RD: if (byte_done && idx != IDX_MAX) idx <= idx + 1'b1;
                    ST_REG_WR: if (byte_done) begin
                        wr_en   <= 1'b1;
                        wr_idx  <= idx;
                        wr_data <= rx_byte;
                        if (idx != IDX_MAX) idx <= idx + 1'b1;
                    end
                    ST_PLD_WR: if (byte_done) begin
                        tx_push <= 1'b1;
                        tx_data <= rx_byte;
                    end
                    ST_PLD_RD: begin
                        if (next_taken) head_vld <= !rx_empty;
                        else if (byte_done && head_vld) begin
                            rx_pop   <= 1'b1;
                            head_vld <= 1'b0;
                        end
                    end
                    ST_IDLE, ST_DISCARD: ;
                    default: ;
                endcase
            end
        end
    end

    // R8: a pop never reaches an empty receive FIFO
    assert_pop_nonempty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |-> !rx_empty);

    // R9: at most one FIFO control pulse at a time
    assert_one_ctrl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tx_flush, rx_flush, tx_reuse}));

    // R1: closing chip-select always returns the machine to idle
    assert_idle_on_close_R1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> state == ST_IDLE);

    // R7: pushes only follow a byte received in the payload-write state
    assert_push_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push |-> ($past(state) == ST_PLD_WR && $past(byte_done)));
endmodule

// File: rtl/reg_bank.sv
module reg_bank
    import radio_spi_pkg::*;
#(
    parameter int          NUM_REGS   = 24,
    parameter int          ADDR_BYTES = 5,
    parameter logic [7:0]  WIDE_RST   = 8'hE7,
    localparam int IW  = $clog2(ADDR_BYTES + 1),
    localparam int IBW = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [4:0]    addr,
    input  logic [IW-1:0] rd_idx,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [7:0]    wr_data,
    input  logic          evt_rx_done,
    input  logic          evt_tx_done,
    input  logic          evt_retry_limit,
    input  logic          tx_full,
    input  logic          tx_empty,
    input  logic          rx_full,
    input  logic          rx_empty,
    output logic [7:0]    status,
    output logic [7:0]    rd_data
);
    localparam logic [IW-1:0] IDX_LIM = IW'(ADDR_BYTES);

    logic [7:0] regs_q [NUM_REGS];
    logic [2:0] flags_q;
    logic [2:0] events;
    logic [NUM_WIDE-1:0] wide_hit;
    logic [7:0] wide_rd [NUM_WIDE];
    logic [7:0] fifo_byte;
    logic       plain_ok;

    assign events    = {evt_rx_done, evt_tx_done, evt_retry_limit};
    assign status    = {1'b0, flags_q, {3{rx_empty}}, tx_full};
    assign fifo_byte = {2'b00, tx_full, tx_empty, 2'b00, rx_full, rx_empty};
    assign plain_ok  = (int'(addr) < NUM_REGS) && (wide_hit == '0)
                       && (addr != A_STATUS) && (addr != A_FIFO);

    for (genvar g = 0; g < NUM_WIDE; g++) begin : g_wide
        logic [7:0] bytes_q [ADDR_BYTES];
        assign wide_hit[g] = (addr == wide_addr(g));
        assign wide_rd[g]  = (rd_idx < IDX_LIM) ? bytes_q[rd_idx[IBW-1:0]] : 8'h00;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < ADDR_BYTES; i++) bytes_q[i] <= WIDE_RST;
            end else if (wr_en && wide_hit[g] && wr_idx < IDX_LIM) begin
                bytes_q[wr_idx[IBW-1:0]] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= 8'h00;
            flags_q <= 3'b000;
        end else begin
            if (wr_en && addr == A_STATUS && wr_idx == '0)
                flags_q <= (flags_q & ~wr_data[6:4]) | events;
            else
                flags_q <= flags_q | events;
            if (wr_en && plain_ok && wr_idx == '0)
                regs_q[addr] <= wr_data;
        end
    end

    always_comb begin
        rd_data = 8'h00;
        if (rd_idx == '0 && addr == A_STATUS)    rd_data = status;
        else if (rd_idx == '0 && addr == A_FIFO) rd_data = fifo_byte;
        else if (rd_idx == '0 && plain_ok)       rd_data = regs_q[addr];
        for (int g = 0; g < NUM_WIDE; g++)
            if (wide_hit[g]) rd_data = wide_rd[g];
    end

    // R6: an event pulse is visible in the status flags on the next cycle
    assert_event_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        evt_rx_done |=> status[6]);

    // R6: a one written to bit 5 clears it when no event competes
    assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_STATUS && wr_idx == '0 && wr_data[5] && !evt_tx_done)
        |=> !status[5]);

    // R6: without events or status writes the flags hold
    assert_flags_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en && addr == A_STATUS) && events == 3'b000) |=> $stable(status[6:4]));
endmodule

// File: rtl/radio_spi_cmd.sv
module radio_spi_cmd
    import radio_spi_pkg::*;
#(
    parameter int         NUM_REGS    = 24,
    parameter int         ADDR_BYTES  = 5,
    parameter logic [7:0] WIDE_RST    = 8'hE7,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       spi_csn,
    input  logic       spi_sck,
    input  logic       spi_mosi,
    output logic       spi_miso,
    output logic       tx_push,
    output logic [7:0] tx_data,
    input  logic       tx_full,
    input  logic       tx_empty,
    output logic       tx_flush,
    output logic       tx_reuse,
    output logic       rx_pop,
    input  logic [7:0] rx_data,
    input  logic       rx_empty,
    input  logic       rx_full,
    output logic       rx_flush,
    input  logic       evt_rx_done,
    input  logic       evt_tx_done,
    input  logic       evt_retry_limit
);
    localparam int IW = $clog2(ADDR_BYTES + 1);

    logic          frame_start, frame_end, next_taken, byte_done;
    logic [7:0]    rx_byte, status, rd_data, next_byte;
    cmd_state_e    state;
    logic [4:0]    addr;
    logic [IW-1:0] idx, wr_idx;
    logic          wr_en;
    logic [7:0]    wr_data;

    always_comb begin
        unique case (state)
            ST_REG_RD: next_byte = rd_data;
            ST_PLD_RD: next_byte = rx_empty ? 8'h00 : rx_data;
            default:   next_byte = 8'h00;
        endcase
    end

    spi_shifter #(.SYNC_STAGES(SYNC_STAGES)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .spi_csn(spi_csn), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
        .first_byte(status), .next_byte(next_byte),
        .spi_miso(spi_miso), .frame_start(frame_start), .frame_end(frame_end),
        .next_taken(next_taken), .byte_done(byte_done), .rx_byte(rx_byte)
    );

    cmd_fsm #(.ADDR_BYTES(ADDR_BYTES)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .frame_start(frame_start), .frame_end(frame_end),
        .byte_done(byte_done), .rx_byte(rx_byte), .next_taken(next_taken),
        .rx_empty(rx_empty), .state(state), .addr(addr), .idx(idx),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .tx_push(tx_push), .tx_data(tx_data), .rx_pop(rx_pop),
        .tx_flush(tx_flush), .rx_flush(rx_flush), .tx_reuse(tx_reuse)
    );

    reg_bank #(.NUM_REGS(NUM_REGS), .ADDR_BYTES(ADDR_BYTES), .WIDE_RST(WIDE_RST)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_idx(idx),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .evt_rx_done(evt_rx_done), .evt_tx_done(evt_tx_done),
        .evt_retry_limit(evt_retry_limit),
        .tx_full(tx_full), .tx_empty(tx_empty), .rx_full(rx_full), .rx_empty(rx_empty),
        .status(status), .rd_data(rd_data)
    );

    // R10: register writes only come out of a write-register frame
    assert_write_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(state) == ST_REG_WR);
endmodule

// File: tb/test_radio_spi_cmd.sv
module test_radio_spi_cmd;
    localparam int HALF = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_csn = 1'b1, spi_sck = 1'b0, spi_mosi = 1'b0;
    logic spi_miso;
    logic tx_push, tx_flush, tx_reuse, rx_pop, rx_flush;
    logic [7:0] tx_data;
    logic tx_full = 1'b0, tx_empty = 1'b1, rx_full = 1'b0;
    logic evt_rx = 1'b0, evt_tx = 1'b0, evt_rt = 1'b0;
    logic [7:0] rx_data;
    logic rx_empty;

    int checks = 0, failures = 0;
    logic [7:0] mo [8];
    logic [7:0] mi [8];
    logic [7:0] rxq [8];
    int rxn = 0;
    logic [7:0] txcap [16];
    int push_n = 0, pop_n = 0, ftx_n = 0, frx_n = 0, reuse_n = 0;

    always #2 clk = ~clk;

    assign rx_data  = (rxn > 0) ? rxq[0] : 8'h00;
    assign rx_empty = (rxn == 0);

    radio_spi_cmd i_radio_spi_cmd (
        .clk(clk), .rst_n(rst_n), .spi_csn(spi_csn), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .tx_push(tx_push),
        .tx_data(tx_data), .tx_full(tx_full), .tx_empty(tx_empty),
        .tx_flush(tx_flush), .tx_reuse(tx_reuse), .rx_pop(rx_pop),
        .rx_data(rx_data), .rx_empty(rx_empty), .rx_full(rx_full),
        .rx_flush(rx_flush), .evt_rx_done(evt_rx), .evt_tx_done(evt_tx),
        .evt_retry_limit(evt_rt)
    );

    always @(posedge clk) begin
        if (tx_push) begin
            if (push_n < 16) txcap[push_n] <= tx_data;
            push_n <= push_n + 1;
        end
        if (rx_pop) begin
            pop_n <= pop_n + 1;
            for (int i = 0; i < 7; i++) rxq[i] <= rxq[i+1];
            rxn <= rxn - 1;
        end
        if (tx_flush) ftx_n <= ftx_n + 1;
        if (rx_flush) frx_n <= frx_n + 1;
        if (tx_reuse) reuse_n <= reuse_n + 1;
    end

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%02h exp=%02h", req, got, exp);
        end
    endtask

    task automatic frame(input int n);
        @(negedge clk) spi_csn = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int b = 0; b < n; b++) begin
            for (int i = 7; i >= 0; i--) begin
                spi_mosi = mo[b][i];
                repeat (HALF) @(negedge clk);
                mi[b][i] = spi_miso;
                spi_sck = 1'b1;
                repeat (HALF) @(negedge clk);
                spi_sck = 1'b0;
            end
        end
        repeat (HALF) @(negedge clk);
        spi_csn = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic rd_reg(input logic [4:0] a, input int n);
        mo[0] = {3'b000, a};
        for (int i = 1; i < 8; i++) mo[i] = 8'h00;
        frame(n + 1);
    endtask

    task automatic t_reset;
        mo[0] = 8'hFF; mo[1] = 8'h00;
        frame(2);
        check("R12 reset status", mi[0], 8'h0E);
        check("R10 nop data", mi[1], 8'h00);
        rd_reg(5'h05, 1);
        check("R12 reset reg05", mi[1], 8'h00);
        check("R2 status in opcode byte", mi[0], 8'h0E);
    endtask

    task automatic t_regs;
        mo[0] = 8'h25; mo[1] = 8'h2C;
        frame(2);
        rd_reg(5'h05, 1);
        check("R3 read back", mi[1], 8'h2C);
        mo[0] = 8'h25; mo[1] = 8'h11; mo[2] = 8'h22;
        frame(3);
        rd_reg(5'h05, 2);
        check("R4 first byte only", mi[1], 8'h11);
        check("R4 beyond width", mi[2], 8'h00);
        mo[0] = 8'h3F; mo[1] = 8'h55;
        frame(2);
        rd_reg(5'h1F, 1);
        check("R3 out of map", mi[1], 8'h00);
    endtask

    task automatic t_wide;
        rd_reg(5'h10, 5);
        for (int i = 1; i <= 5; i++) check("R5 reset E7", mi[i], 8'hE7);
        mo[0] = 8'h30;
        for (int i = 1; i <= 5; i++) mo[i] = 8'(i);
        frame(6);
        rd_reg(5'h10, 6);
        for (int i = 1; i <= 5; i++) check("R5 wide readback", mi[i], 8'(i));
        check("R5 past last byte", mi[6], 8'h00);
        rd_reg(5'h0A, 1);
        check("R5 other wide untouched", mi[1], 8'hE7);
    endtask

    task automatic t_status;
        @(negedge clk) begin evt_rx = 1; evt_tx = 1; evt_rt = 1; end
        @(negedge clk) begin evt_rx = 0; evt_tx = 0; evt_rt = 0; end
        rd_reg(5'h07, 1);
        check("R6 flags set", mi[0], 8'h7E);
        check("R6 status via read", mi[1], 8'h7E);
        mo[0] = 8'h27; mo[1] = 8'h20;
        frame(2);
        mo[0] = 8'h27; mo[1] = 8'h0F;
        frame(2);
        check("R6 clear one flag", mi[0], 8'h5E);
        mo[0] = 8'h27; mo[1] = 8'h50;
        frame(2);
        check("R6 zero-write no effect", mi[0], 8'h5E);
        mo[0] = 8'hFF;
        frame(1);
        check("R6 all cleared", mi[0], 8'h0E);
    endtask

    task automatic t_fifo_stat;
        tx_full = 1'b1; tx_empty = 1'b0;
        mo[0] = 8'h37; mo[1] = 8'hFF;
        frame(2);
        check("R1 tx full bit0", mi[0], 8'h0F);
        rd_reg(5'h17, 1);
        check("R11 fifo status", mi[1], 8'h21);
        tx_full = 1'b0; tx_empty = 1'b1;
    endtask

    task automatic t_pld_wr;
        int base;
        base = push_n;
        mo[0] = 8'hA0; mo[1] = 8'h3C; mo[2] = 8'h96; mo[3] = 8'h01;
        frame(4);
        check("R7 push count", 8'(push_n - base), 8'd3);
        check("R7 push byte0", txcap[base], 8'h3C);
        check("R7 push byte2", txcap[base+2], 8'h01);
    endtask

    task automatic t_pld_rd;
        @(negedge clk) begin rxq[0] = 8'h5A; rxq[1] = 8'hC3; rxn = 2; end
        pop_n = 0;
        mo[0] = 8'h61; mo[1] = 0; mo[2] = 0; mo[3] = 0;
        frame(4);
        check("R1 status rx not empty", mi[0], 8'h00);
        check("R8 head byte", mi[1], 8'h5A);
        check("R8 second byte", mi[2], 8'hC3);
        check("R8 empty reads zero", mi[3], 8'h00);
        check("R8 pop count", 8'(pop_n), 8'd2);
    endtask

    task automatic t_flush;
        mo[0] = 8'hE1; frame(1);
        mo[0] = 8'hE2; mo[1] = 8'hE2; frame(2);
        mo[0] = 8'hE3; frame(1);
        check("R9 tx flush once", 8'(ftx_n), 8'd1);
        check("R9 rx flush once", 8'(frx_n), 8'd1);
        check("R9 reuse once", 8'(reuse_n), 8'd1);
    endtask

    task automatic t_unknown;
        int base;
        base = push_n;
        mo[0] = 8'h80; mo[1] = 8'h12; mo[2] = 8'h34;
        frame(3);
        check("R10 unknown miso", mi[1], 8'h00);
        check("R10 no push", 8'(push_n - base), 8'd0);
        check("R10 no flush", 8'(ftx_n + frx_n + reuse_n), 8'd3);
        rd_reg(5'h05, 1);
        check("R10 regs untouched", mi[1], 8'h11);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset;
        t_regs;
        t_wide;
        t_status;
        t_fifo_stat;
        t_pld_wr;
        t_pld_rd;
        t_flush;
        t_unknown;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule